// File: doc/BRIEF.md
# ADC Conversion Sequencer with Selection Shadowing

This block is the digital control for a successive-approximation converter. It decides when a conversion starts, measures how long it runs, and marks the sample-and-hold instant. It also decides which channel and reference the analog front end sees. Time is counted in half ADC-clock units. Two one-cycle strobes from the prescaler advance that count: `adc_rise` marks a rising ADC clock edge and `adc_fall` marks a falling one. Sample points that fall on a half cycle are therefore exact.

A conversion can be requested in three ways: a software start pulse, an external trigger pulse, or an automatic restart in free-running mode. The length and the sample point of a conversion depend on its kind:

| Kind | Sample point (half units) | Completion (half units) |
|------|---------------------------|-------------------------|
| first after enable | 27 | 50 |
| single | 3 | 26 |
| triggered | 4 | 27 |
| free-running | 5 | 28 |

The CPU writes the selection into a temporary register. That value is copied to the active selection only while no conversion runs, and again in the last ADC cycle of a conversion.

At completion the block captures the converter's result word and raises a sticky flag. Selection writes are a valid-only input (`sel_wr` qualifies `sel_wdata`) and are never back-pressured: every write is accepted in the cycle it is presented. Every other pin is a plain level or pulse.

Top module: `adcseq_top`

## Requirements
- R1: While no conversion runs, a selection write presented in one cycle appears on `sel_active` in the next cycle.
- R2: A start or trigger request is registered first. The conversion begins on the first `adc_rise` strobe sampled in a later cycle, and `busy` rises with that strobe.
- R3: The first conversion after `en` goes high has its sample pulse 27 half units after its start and its completion 50 half units after its start.
- R4: A conversion launched by `start` has its sample pulse at 3 half units and its completion at 26 half units.
- R5: A `trig` pulse while idle with `auto_en` high launches a conversion with its sample pulse at 4 half units and its completion at 27. A trigger while `auto_en` is low is ignored.
- R6: With `free_run` and `auto_en` high, a new conversion starts at each completion, on the same strobe if that strobe is a rise. Its sample pulse is at 5 half units and its completion at 28. A selection written after a result first affects the result after the next one.
- R7: From the start of a conversion until the half count reaches completion minus 2, selection writes do not change `sel_active`.
- R8: A selection written once the half count has reached completion minus 2 reaches `sel_active` before completion and applies to the next conversion.
- R9: At completion `done_flag` is set and `result` takes `res_in` in the same cycle. The flag stays set until `flag_clr`, and a new completion wins over a clear in the same cycle.
- R10: While `en` is low, any running conversion is dropped (`busy` falls one cycle later), `start` is ignored and the selection is transparent. The next conversion after `en` rises is of the first kind.
- R11: Clearing `auto_en` cancels pending triggers and free-running restarts. After the running conversion completes, the block stays idle with a transparent selection.
- R12: `sample_stb` is a one-cycle pulse that occurs only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| adc_rise | input | 1 | Strobe, one cycle per rising ADC clock edge |
| adc_fall | input | 1 | Strobe, one cycle per falling ADC clock edge |
| en | input | 1 | Converter enable |
| start | input | 1 | Software start pulse |
| auto_en | input | 1 | Allows trigger starts and free-running restarts |
| trig | input | 1 | External trigger pulse |
| free_run | input | 1 | Restart automatically at each completion |
| sel_wr | input | 1 | Valid strobe for a selection write |
| sel_wdata | input | SEL_W | Channel and reference selection to write |
| res_in | input | RES_W | Result word from the converter |
| flag_clr | input | 1 | Clears the completion flag |
| sel_active | output | SEL_W | Selection driven to the analog front end |
| sample_stb | output | 1 | Sample-and-hold instant |
| busy | output | 1 | Conversion in progress |
| done_flag | output | 1 | Sticky completion flag |
| result | output | RES_W | Result captured at completion |

## Verification
The bench measures, in clock cycles, the sample and completion offsets of every conversion kind, including the back-to-back free-running chain. A wrong half-unit constant, or a restart that waits one extra edge, shows up as an offset mismatch.

The bench writes the selection just after a conversion starts, two ADC cycles before its end, and inside its final ADC cycle. A shadow that never freezes changes the result, and one that reopens too early or too late changes `sel_active` at the wrong check.

It also issues a start in the middle of an ADC period, a trigger while triggers are disabled, and a disable in mid-conversion. These catch a launch that skips the ADC edge, a stray conversion, and a flag raised by an abandoned conversion.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  typedef enum logic [1:0] {
    KIND_FIRST  = 2'd0,
    KIND_SINGLE = 2'd1,
    KIND_TRIG   = 2'd2,
    KIND_FREE   = 2'd3
  } conv_kind_e;

  function automatic int max_of4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/adcseq_launch.sv
module adcseq_launch
  import adcseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rise,
  input  logic       en,
  input  logic       auto_en,
  input  logic       free_run,
  input  logic       start,
  input  logic       trig,
  input  logic       busy,
  input  logic       end_now,
  output logic       launch,
  output conv_kind_e launch_kind
);

  logic       pend_q;
  conv_kind_e pend_kind_q;
  logic       first_q;
  logic       restart_now;
  logic       chain_req;

  // Free-running chain is only honoured while triggering is allowed.
  assign chain_req   = end_now && free_run && auto_en;
  assign restart_now = chain_req && rise;
  assign launch      = en && rise && (pend_q || restart_now);

  always_comb begin
    if (first_q)          launch_kind = KIND_FIRST;
    else if (restart_now) launch_kind = KIND_FREE;
    else                  launch_kind = pend_kind_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_kind_q <= KIND_SINGLE;
      first_q     <= 1'b1;
    end else if (!en) begin
      pend_q  <= 1'b0;
      first_q <= 1'b1;
    end else if (launch) begin
      pend_q  <= 1'b0;
      first_q <= 1'b0;
    end else if (chain_req) begin
      // completion on a falling edge: restart waits for the next rise
      pend_q      <= 1'b1;
      pend_kind_q <= KIND_FREE;
    end else if (pend_q && (pend_kind_q != KIND_SINGLE) && !auto_en) begin
      pend_q <= 1'b0;
    end else if (!busy && !pend_q) begin
      if (start) begin
        pend_q      <= 1'b1;
        pend_kind_q <= KIND_SINGLE;
      end else if (trig && auto_en) begin
        pend_q      <= 1'b1;
        pend_kind_q <= KIND_TRIG;
      end
    end
  end

endmodule

// File: rtl/adcseq_timer.sv
module adcseq_timer
  import adcseq_pkg::*;
#(
  parameter int FIRST_SMP_H = 27,
  parameter int FIRST_END_H = 50,
  parameter int SNGL_SMP_H  = 3,
  parameter int SNGL_END_H  = 26,
  parameter int TRIG_SMP_H  = 4,
  parameter int TRIG_END_H  = 27,
  parameter int FREE_SMP_H  = 5,
  parameter int FREE_END_H  = 28,
  parameter int CNT_W       = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       rise,
  input  logic       fall,
  input  logic       launch,
  input  conv_kind_e launch_kind,
  output logic       busy,
  output logic       end_now,
  output logic       sample_stb,
  output logic       open_win
);

  // Per-kind compare points, precomputed as counter-width constants.
  localparam logic [CNT_W-1:0] FIRST_SMP_M1 = CNT_W'(FIRST_SMP_H - 1);
  localparam logic [CNT_W-1:0] FIRST_END_M1 = CNT_W'(FIRST_END_H - 1);
  localparam logic [CNT_W-1:0] FIRST_OPEN   = CNT_W'(FIRST_END_H - 2);
  localparam logic [CNT_W-1:0] SNGL_SMP_M1  = CNT_W'(SNGL_SMP_H - 1);
  localparam logic [CNT_W-1:0] SNGL_END_M1  = CNT_W'(SNGL_END_H - 1);
  localparam logic [CNT_W-1:0] SNGL_OPEN    = CNT_W'(SNGL_END_H - 2);
  localparam logic [CNT_W-1:0] TRIG_SMP_M1  = CNT_W'(TRIG_SMP_H - 1);
  localparam logic [CNT_W-1:0] TRIG_END_M1  = CNT_W'(TRIG_END_H - 1);
  localparam logic [CNT_W-1:0] TRIG_OPEN    = CNT_W'(TRIG_END_H - 2);
  localparam logic [CNT_W-1:0] FREE_SMP_M1  = CNT_W'(FREE_SMP_H - 1);
  localparam logic [CNT_W-1:0] FREE_END_M1  = CNT_W'(FREE_END_H - 1);
  localparam logic [CNT_W-1:0] FREE_OPEN    = CNT_W'(FREE_END_H - 2);

  logic [CNT_W-1:0] cnt_q;
  conv_kind_e       kind_q;
  logic [CNT_W-1:0] smp_m1;
  logic [CNT_W-1:0] end_m1;
  logic [CNT_W-1:0] open_from;
  logic             step;
  logic             smp_now;

  always_comb begin
    smp_m1    = SNGL_SMP_M1;
    end_m1    = SNGL_END_M1;
    open_from = SNGL_OPEN;
    case (kind_q)
      KIND_FIRST: begin
        smp_m1 = FIRST_SMP_M1; end_m1 = FIRST_END_M1; open_from = FIRST_OPEN;
      end
      KIND_TRIG: begin
        smp_m1 = TRIG_SMP_M1; end_m1 = TRIG_END_M1; open_from = TRIG_OPEN;
      end
      KIND_FREE: begin
        smp_m1 = FREE_SMP_M1; end_m1 = FREE_END_M1; open_from = FREE_OPEN;
      end
      default: begin
        smp_m1 = SNGL_SMP_M1; end_m1 = SNGL_END_M1; open_from = SNGL_OPEN;
      end
    endcase
  end

  assign step     = busy && en && (rise || fall);
  assign end_now  = step && (cnt_q == end_m1);
  assign smp_now  = step && (cnt_q == smp_m1);
  assign open_win = !busy || (cnt_q >= open_from);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      cnt_q      <= '0;
      kind_q     <= KIND_SINGLE;
      sample_stb <= 1'b0;
    end else begin
      sample_stb <= smp_now;
      if (!en) begin
        busy  <= 1'b0;
        cnt_q <= '0;
      end else if (launch) begin
        busy   <= 1'b1;
        cnt_q  <= '0;
        kind_q <= launch_kind;
      end else if (end_now) begin
        busy  <= 1'b0;
        cnt_q <= '0;
      end else if (step) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/adcseq_selshadow.sv
module adcseq_selshadow #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [SEL_W-1:0] wdata,
  input  logic             open_win,
  output logic [SEL_W-1:0] active
);

  logic [SEL_W-1:0] tmp_q;
  logic [SEL_W-1:0] tmp_next;

  assign tmp_next = wr ? wdata : tmp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmp_q  <= '0;
      active <= '0;
    end else begin
      tmp_q <= tmp_next;
      if (open_win) active <= tmp_next;
    end
  end

endmodule

// File: rtl/adcseq_result.sv
module adcseq_result #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             end_now,
  input  logic             flag_clr,
  input  logic [RES_W-1:0] res_in,
  output logic             done_flag,
  output logic [RES_W-1:0] result
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_flag <= 1'b0;
      result    <= '0;
    end else begin
      if (end_now) begin
        done_flag <= 1'b1;
        result    <= res_in;
      end else if (flag_clr) begin
        done_flag <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
  import adcseq_pkg::*;
#(
  parameter int SEL_W       = 4,
  parameter int RES_W       = 10,
  parameter int FIRST_SMP_H = 27,
  parameter int FIRST_END_H = 50,
  parameter int SNGL_SMP_H  = 3,
  parameter int SNGL_END_H  = 26,
  parameter int TRIG_SMP_H  = 4,
  parameter int TRIG_END_H  = 27,
  parameter int FREE_SMP_H  = 5,
  parameter int FREE_END_H  = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adc_rise,
  input  logic             adc_fall,
  input  logic             en,
  input  logic             start,
  input  logic             auto_en,
  input  logic             trig,
  input  logic             free_run,
  input  logic             sel_wr,
  input  logic [SEL_W-1:0] sel_wdata,
  input  logic [RES_W-1:0] res_in,
  input  logic             flag_clr,
  output logic [SEL_W-1:0] sel_active,
  output logic             sample_stb,
  output logic             busy,
  output logic             done_flag,
  output logic [RES_W-1:0] result
);

  localparam int MAX_END_H = max_of4(FIRST_END_H, SNGL_END_H, TRIG_END_H, FREE_END_H);
  localparam int CNT_W     = $clog2(MAX_END_H + 1);

  logic       launch;
  conv_kind_e launch_kind;
  logic       end_now;
  logic       open_win;

  adcseq_launch u_launch (
    .clk(clk), .rst_n(rst_n), .rise(adc_rise), .en(en), .auto_en(auto_en),
    .free_run(free_run), .start(start), .trig(trig), .busy(busy),
    .end_now(end_now), .launch(launch), .launch_kind(launch_kind)
  );

  adcseq_timer #(
    .FIRST_SMP_H(FIRST_SMP_H), .FIRST_END_H(FIRST_END_H),
    .SNGL_SMP_H(SNGL_SMP_H),   .SNGL_END_H(SNGL_END_H),
    .TRIG_SMP_H(TRIG_SMP_H),   .TRIG_END_H(TRIG_END_H),
    .FREE_SMP_H(FREE_SMP_H),   .FREE_END_H(FREE_END_H),
    .CNT_W(CNT_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .en(en), .rise(adc_rise), .fall(adc_fall),
    .launch(launch), .launch_kind(launch_kind), .busy(busy),
    .end_now(end_now), .sample_stb(sample_stb), .open_win(open_win)
  );

  adcseq_selshadow #(.SEL_W(SEL_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .wr(sel_wr), .wdata(sel_wdata),
    .open_win(open_win), .active(sel_active)
  );

  adcseq_result #(.RES_W(RES_W)) u_result (
    .clk(clk), .rst_n(rst_n), .end_now(end_now), .flag_clr(flag_clr),
    .res_in(res_in), .done_flag(done_flag), .result(result)
  );

endmodule

// File: rtl/adcseq_checker.sv
module adcseq_checker #(
  parameter int SEL_W = 4,
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             busy,
  input logic             sample_stb,
  input logic             done_flag,
  input logic             open_win,
  input logic [SEL_W-1:0] sel_active,
  input logic [RES_W-1:0] result
);

  assert_sample_in_conv_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> busy);

  assert_sample_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);

  assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !open_win) |=> $stable(sel_active));

  assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $past(busy));

  assert_result_with_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done_flag);

  assert_disable_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);

endmodule

bind adcseq_top adcseq_checker #(.SEL_W(SEL_W), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .busy(busy), .sample_stb(sample_stb),
  .done_flag(done_flag), .open_win(open_win), .sel_active(sel_active),
  .result(result)
);

// File: tb/adcseq_tb_top.sv
`timescale 1ns/1ps
module adcseq_top_tb_top;

  localparam int SEL_W = 4;
  localparam int RES_W = 10;
  localparam int HALF  = 4;  // clock cycles per half ADC clock

  typedef struct {
    int               smp;
    int               fin;
    logic [SEL_W-1:0] sel;
    string            req;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic adc_rise = 1'b0, adc_fall = 1'b0;
  logic en = 1'b0, start = 1'b0, auto_en = 1'b0, trig = 1'b0, free_run = 1'b0;
  logic sel_wr = 1'b0;
  logic [SEL_W-1:0] sel_wdata = '0;
  logic [RES_W-1:0] model_res = '0;
  logic mon_clr = 1'b0, man_clr = 1'b0;
  logic flag_clr;
  logic [SEL_W-1:0] sel_active;
  logic sample_stb, busy, done_flag;
  logic [RES_W-1:0] result;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int ph = 0;
  bit auto_clr = 1'b1;
  bit done_run = 1'b0;
  item_t sb_q[$];

  bit mon_bp = 1'b0, mon_dp = 1'b0;
  int mon_t0 = 0, mon_ts = 0;
  item_t mon_it;

  assign flag_clr = mon_clr | man_clr;

  always #4 clk = ~clk;  // 125 MHz

  adcseq_top dut_i (
    .clk(clk), .rst_n(rst_n), .adc_rise(adc_rise), .adc_fall(adc_fall),
    .en(en), .start(start), .auto_en(auto_en), .trig(trig), .free_run(free_run),
    .sel_wr(sel_wr), .sel_wdata(sel_wdata), .res_in(model_res), .flag_clr(flag_clr),
    .sel_active(sel_active), .sample_stb(sample_stb), .busy(busy),
    .done_flag(done_flag), .result(result)
  );

  function automatic logic [RES_W-1:0] res_of(logic [SEL_W-1:0] s);
    return RES_W'(s) * RES_W'(37) + RES_W'(5);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
    #1;
  endtask

  task automatic write_sel(logic [SEL_W-1:0] v);
    sel_wr = 1'b1; sel_wdata = v;
    tick;
    sel_wr = 1'b0;
  endtask

  task automatic pulse_start;
    start = 1'b1;
    tick;
    start = 1'b0;
  endtask

  task automatic push(int smp, int fin, logic [SEL_W-1:0] sel, string req);
    item_t it;
    it.smp = smp; it.fin = fin; it.sel = sel; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic wait_busy(output int c0);
    while (!busy) tick;
    c0 = cyc;
  endtask

  task automatic drain;
    while (sb_q.size() != 0 || busy) tick;
    repeat (3) tick;
  endtask

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // ADC clock edge strobes: rise every 8 cycles, fall 4 cycles later
  initial forever begin
    @(negedge clk);
    adc_rise = (ph == 0);
    adc_fall = (ph == 4);
    ph = (ph + 1) % 8;
  end

  // Monitor: measures offsets and pops the scoreboard on each completion
  initial forever begin
    @(negedge clk);
    mon_clr = 1'b0;
    if (rst_n) begin
      if (busy && !mon_bp) mon_t0 = cyc;
      if (sample_stb) begin
        mon_ts = cyc;
        model_res = res_of(sel_active);
        check(busy, "R12", "sample pulse outside conversion", 0, 1);
      end
      if (done_flag && !mon_dp) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R10", "unexpected completion", 1, 0);
        end else begin
          mon_it = sb_q.pop_front();
          check(mon_ts - mon_t0 == mon_it.smp * HALF, mon_it.req, "sample offset",
                mon_ts - mon_t0, mon_it.smp * HALF);
          check(cyc - mon_t0 == mon_it.fin * HALF, mon_it.req, "completion offset",
                cyc - mon_t0, mon_it.fin * HALF);
          check(result == res_of(mon_it.sel), "R9", "captured result",
                int'(result), int'(res_of(mon_it.sel)));
        end
        if (busy) mon_t0 = cyc;
        if (auto_clr) mon_clr = 1'b1;
      end
      mon_bp = busy;
      mon_dp = done_flag;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_run) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int c0;
    repeat (3) tick;
    rst_n = 1'b1;
    tick;
    check(busy == 1'b0, "R10", "busy after reset", int'(busy), 0);
    check(done_flag == 1'b0, "R9", "flag after reset", int'(done_flag), 0);
    check(sample_stb == 1'b0, "R12", "sample after reset", int'(sample_stb), 0);
    check(sel_active == '0, "R1", "selection after reset", int'(sel_active), 0);

    // disabled: selection transparent, start ignored
    write_sel(4'd3);
    check(sel_active == 4'd3, "R1", "idle write transparent", int'(sel_active), 3);
    pulse_start;
    repeat (40) tick;
    check(busy == 1'b0, "R10", "start ignored while disabled", int'(busy), 0);

    // first conversion after enable
    en = 1'b1;
    tick;
    push(27, 50, 4'd3, "R3");
    pulse_start;
    drain;

    // single conversion: launch waits for a rise strobe, freeze after start
    write_sel(4'd7);
    while (!adc_rise) tick;
    tick;
    push(3, 26, 4'd7, "R4");
    pulse_start;
    for (int i = 0; i < 5; i++) begin
      check(busy == 1'b0, "R2", "busy before next rise strobe", int'(busy), 0);
      tick;
    end
    wait_busy(c0);
    tick;
    write_sel(4'd9);
    tick;
    check(sel_active == 4'd7, "R7", "selection frozen after start", int'(sel_active), 7);
    drain;
    check(sel_active == 4'd9, "R8", "pending write taken at window", int'(sel_active), 9);

    // reopening in the last ADC cycle
    write_sel(4'd2);
    push(3, 26, 4'd2, "R4");
    pulse_start;
    wait_busy(c0);
    while (cyc < c0 + 90) tick;
    write_sel(4'd11);
    check(sel_active == 4'd2, "R7", "write two ADC cycles early held", int'(sel_active), 2);
    while (cyc < c0 + 96) tick;
    write_sel(4'd12);
    while (cyc < c0 + 100) tick;
    check(busy == 1'b1, "R8", "still converting in last cycle", int'(busy), 1);
    check(sel_active == 4'd12, "R8", "last-cycle write applied", int'(sel_active), 12);
    drain;

    // sticky flag
    auto_clr = 1'b0;
    write_sel(4'd6);
    push(3, 26, 4'd6, "R4");
    pulse_start;
    while (sb_q.size() != 0) tick;
    repeat (20) tick;
    check(done_flag == 1'b1, "R9", "flag sticky", int'(done_flag), 1);
    man_clr = 1'b1;
    tick;
    man_clr = 1'b0;
    check(done_flag == 1'b0, "R9", "flag cleared", int'(done_flag), 0);
    auto_clr = 1'b1;
    tick;

    // triggers
    trig = 1'b1; tick; trig = 1'b0;
    repeat (20) tick;
    check(busy == 1'b0, "R5", "trigger ignored while disabled", int'(busy), 0);
    auto_en = 1'b1;
    write_sel(4'd5);
    push(4, 27, 4'd5, "R5");
    trig = 1'b1; tick; trig = 1'b0;
    drain;

    // free-running chain
    free_run = 1'b1;
    write_sel(4'd1);
    push(3, 26, 4'd1, "R4");
    push(5, 28, 4'd1, "R6");
    push(5, 28, 4'd8, "R6");
    pulse_start;
    while (sb_q.size() != 2) tick;
    write_sel(4'd8);
    check(sel_active == 4'd1, "R6", "next conversion keeps old selection",
          int'(sel_active), 1);
    while (sb_q.size() != 1) tick;
    auto_en = 1'b0;
    free_run = 1'b0;
    while (sb_q.size() != 0) tick;
    repeat (3) tick;
    check(busy == 1'b0, "R11", "chain stops after clearing", int'(busy), 0);
    write_sel(4'd13);
    check(sel_active == 4'd13, "R11", "selection transparent after chain",
          int'(sel_active), 13);

    // disable mid-conversion
    write_sel(4'd4);
    pulse_start;
    wait_busy(c0);
    repeat (20) tick;
    en = 1'b0;
    tick;
    tick;
    check(busy == 1'b0, "R10", "disable drops conversion", int'(busy), 0);
    write_sel(4'd14);
    check(sel_active == 4'd14, "R10", "selection transparent when disabled",
          int'(sel_active), 14);
    repeat (150) tick;
    check(done_flag == 1'b0, "R10", "no flag from dropped conversion", int'(done_flag), 0);

    // re-enable: first kind again
    en = 1'b1;
    tick;
    push(27, 50, 4'd14, "R10");
    pulse_start;
    drain;
    check(sb_q.size() == 0, "R9", "scoreboard empty", sb_q.size(), 0);

    done_run = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule